// File: doc/BRIEF.md
# DMA Transfer Counter and Request Controller

This block connects a host register port to the DMA side of a buffer memory. Software programs a configuration register and loads a byte count into the transfer counter, both over a small register bus. The block decodes which buffer is targeted and which way data moves. Once armed, it raises a DMA request line in bursts of the chosen length. It counts down the bytes moved on each acknowledged data strobe.

When the count reaches zero, the block emits a one-cycle end-of-transfer pulse and a buffer-status update pulse, and it sets a sticky interrupt flag. Software clears that flag with a write-one-to-clear access. The DMA enable bit does not clear itself. After a transfer, the request stays low until software clears the enable bit and sets it again. The external DMA controller is represented only by its acknowledge and strobe inputs.

Register map (`reg_addr`):
- 0: configuration. Bit 7 enables the counter. Bits 6:5 set the burst length. Bit 4 enables DMA. Bits 3:1 select the buffer type. Bit 0 sets the direction.
- 1: transfer counter.
- 2: interrupt status. Bit 2 is the end-of-transfer flag.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: After reset, all three registers read 0, `dreq`, `eot_pulse`, `buf_upd`, `irq_eot`, `dir_write` and `burst_err` are 0, and `buf_sel` is 5'b00001.
- R2: A write to address 0 stores bits 7:0. Reading address 0 returns them, with bits 15:8 reading 0. Any other address (3) reads 0.
- R3: The buffer field (config bits 3:1) drives `buf_sel` one-hot, as follows:
  - 000 sets bit 0 (isochronous buffer 0).
  - 001 sets bit 1 (isochronous buffer 1).
  - 010 sets bit 2 (interrupt buffer).
  - 011 sets bit 3 (asynchronous buffer).
  - Any value with its top bit set sets bit 4 (direct addressing).
  - `dir_write` equals config bit 0, where 1 means write to the buffer memory and 0 means read from it.
- R4: A write to the transfer counter takes effect only while config bit 7 is 1 and no transfer is active. Otherwise the counter keeps its value.
- R5: The request is armed only by a configuration write that takes bit 4 from 0 to 1, with bit 7 written as 1, a non-zero counter and a legal burst code. Loading a count after DMA enable is already high does not raise `dreq`.
- R6: Burst code 00 gives 1 beat, 01 gives 4 beats and 10 gives 8 beats. `dreq` falls after the last beat of each burst, stays low exactly one cycle, and rises again if bytes remain.
- R7: When the remaining count is below the byte size of a full burst, the block issues single-beat bursts instead.
- R8: Each cycle with `dreq`, `dack` and `dstrobe` all high lowers the counter by DATA_W/8 bytes, saturating at 0. No other cycle changes it. Address 1 reads the remaining count.
- R9: Code 11 is illegal, and so is code 10 when DATA_W is 32. While DMA is enabled with an illegal code, `burst_err` is 1 and `dreq` stays 0.
- R10: On the beat that empties the counter, `eot_pulse` and `buf_upd` pulse for one cycle and `irq_eot` (status bit 2) is set. `dreq` then stays low while bit 4 remains 1.
- R11: Writing status bit 2 as 1 clears `irq_eot`. Writing it as 0 has no effect.
- R12: A configuration write that clears bit 4 during a transfer drops `dreq` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| dreq | output | 1 | DMA request |
| dack | input | 1 | DMA acknowledge |
| dstrobe | input | 1 | Data strobe for one beat |
| eot_pulse | output | 1 | End-of-transfer pulse |
| buf_upd | output | 1 | Buffer-status update pulse |
| irq_eot | output | 1 | Sticky end-of-transfer interrupt flag |
| buf_sel | output | 5 | One-hot buffer type |
| dir_write | output | 1 | 1 = write to buffer memory |
| burst_err | output | 1 | Illegal burst code while DMA enabled |

## Verification
Transfers run with byte counts that fill whole bursts exactly, that leave a tail shorter than a burst, and that are odd. The resulting burst runs, beat totals and one-cycle gaps show whether the block sizes bursts from the remaining count and saturates correctly. Stalls on `dack` and `dstrobe` show that only true strobes consume bytes. Arming with a zero count, loading a count after arming, an illegal burst code and an abort in mid-transfer each check a separate gate on the request line.

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        dreq,
  input  logic        dack,
  input  logic        dstrobe,
  output logic        eot_pulse,
  output logic        buf_upd,
  output logic        irq_eot,
  output logic [4:0]  buf_sel,
  output logic        dir_write,
  output logic        burst_err
);
  localparam logic [CNT_W-1:0] BPB = CNT_W'(DATA_W / 8);

  logic [7:0]       cfg;
  logic [CNT_W-1:0] cnt;
  logic             active, dreq_q, eot_q, irq_q;
  logic [3:0]       beats;

  function automatic logic bad_code(input logic [1:0] code);
    return (code == 2'b11) || (DATA_W == 32 && code == 2'b10);
  endfunction

  wire cfg_wr = reg_wr && reg_addr == 2'd0;
  wire cnt_wr = reg_wr && reg_addr == 2'd1;
  wire irq_wr = reg_wr && reg_addr == 2'd2;
  wire cnt_en = cfg[7];
  wire dma_en = cfg[4];
  wire xfer   = dreq_q && dack && dstrobe;

  logic [3:0] beats_cfg;
  always_comb begin
    case (cfg[6:5])
      2'b01:   beats_cfg = 4'd4;
      2'b10:   beats_cfg = 4'd8;
      default: beats_cfg = 4'd1;
    endcase
  end

  wire [CNT_W-1:0] burst_bytes = CNT_W'(beats_cfg) * BPB;
  wire [CNT_W-1:0] cnt_next    = (cnt > BPB) ? cnt - BPB : '0;
  wire             done        = xfer && cnt_next == '0;
  wire             arm = cfg_wr && reg_wdata[4] && !dma_en && reg_wdata[7]
                         && cnt != '0 && !bad_code(reg_wdata[6:5]);
  wire             stop = cfg_wr && !reg_wdata[4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg    <= '0;
      cnt    <= '0;
      active <= 1'b0;
      dreq_q <= 1'b0;
      beats  <= '0;
      eot_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (cfg_wr) cfg <= reg_wdata[7:0];

      if (xfer) cnt <= cnt_next;
      else if (cnt_wr && cnt_en && !active) cnt <= reg_wdata[CNT_W-1:0];

      if (arm) active <= 1'b1;
      else if (done || stop) active <= 1'b0;

      if (stop) dreq_q <= 1'b0;
      else if (xfer) begin
        beats <= beats - 4'd1;
        if (beats == 4'd1 || cnt_next == '0) dreq_q <= 1'b0;
      end else if (active && !dreq_q && cnt != '0) begin
        dreq_q <= 1'b1;
        beats  <= (cnt >= burst_bytes) ? beats_cfg : 4'd1;
      end

      eot_q <= done;

      if (done) irq_q <= 1'b1;
      else if (irq_wr && reg_wdata[2]) irq_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {8'h00, cfg};
      2'd1:    reg_rdata = 16'(cnt);
      2'd2:    reg_rdata = {13'd0, irq_q, 2'b00};
      default: reg_rdata = '0;
    endcase
  end

  assign dreq      = dreq_q;
  assign eot_pulse = eot_q;
  assign buf_upd   = eot_q;
  assign irq_eot   = irq_q;
  assign dir_write = cfg[0];
  assign buf_sel   = cfg[3] ? 5'b10000 : (5'b00001 << cfg[2:1]);
  assign burst_err = dma_en && bad_code(cfg[6:5]);
endmodule

module dma_xfer_ctrl_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             dreq,
  input logic             dack,
  input logic             dstrobe,
  input logic             eot_pulse,
  input logic             irq_eot,
  input logic [4:0]       buf_sel,
  input logic [7:0]       cfg,
  input logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] BPB = CNT_W'(DATA_W / 8);

  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dreq && dack && dstrobe) && !reg_wr |=> $stable(cnt));

  // R8
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dreq && dack && dstrobe |=> cnt == (($past(cnt) > BPB) ? $past(cnt) - BPB : '0));

  // R5
  dreq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dreq |-> cfg[4] && cfg[7]);

  // R10
  eot_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eot_pulse |-> irq_eot && !dreq);

  // R10
  eot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eot_pulse |=> !eot_pulse);

  // R3
  buf_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(buf_sel) == 1);
endmodule

bind dma_xfer_ctrl dma_xfer_ctrl_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .dreq(dreq), .dack(dack),
  .dstrobe(dstrobe), .eot_pulse(eot_pulse), .irq_eot(irq_eot),
  .buf_sel(buf_sel), .cfg(cfg), .cnt(cnt)
);

// File: tb/dma_xfer_ctrl_bench.sv
module dma_xfer_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        dreq, dack = 1'b0, dstrobe = 1'b0;
  logic        eot_pulse, buf_upd, irq_eot, dir_write, burst_err;
  logic [4:0]  buf_sel;
  int checks = 0, failures = 0, cycles = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  dma_xfer_ctrl u_dma_xfer_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .dack(dack),
    .dstrobe(dstrobe), .eot_pulse(eot_pulse), .buf_upd(buf_upd),
    .irq_eot(irq_eot), .buf_sel(buf_sel), .dir_write(dir_write),
    .burst_err(burst_err)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    int v;
    for (int a = 0; a < 3; a++) begin
      rd(2'(a), v);
      check("R1 reg read", v, 0);
    end
    check("R1 dreq", int'(dreq), 0);
    check("R1 buf_sel", int'(buf_sel), 1);
    check("R1 dir_write", int'(dir_write), 0);
    check("R1 irq_eot", int'(irq_eot), 0);
    check("R1 burst_err", int'(burst_err), 0);
  endtask

  task automatic t_cfg_decode();
    int v;
    wr(2'd0, 16'hAB6E);
    rd(2'd0, v);
    check("R2 cfg readback", v, 16'h006E);
    rd(2'd3, v);
    check("R2 unused addr", v, 0);
    for (int f = 0; f < 8; f++) begin
      for (int d = 0; d < 2; d++) begin
        wr(2'd0, 16'((f << 1) | d));
        check("R3 buf_sel", int'(buf_sel), (f < 4) ? (1 << f) : 16);
        check("R3 dir_write", int'(dir_write), d);
      end
    end
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_cnt_gate();
    int v;
    wr(2'd1, 16'd100);
    rd(2'd1, v);
    check("R4 load ignored when counter disabled", v, 0);
    wr(2'd0, 16'h0080);
    wr(2'd1, 16'd100);
    rd(2'd1, v);
    check("R4 load accepted", v, 100);
  endtask

  task automatic t_no_arm();
    int hi = 0;
    dack = 1'b1; dstrobe = 1'b1;
    wr(2'd1, 16'd0);
    wr(2'd0, 16'h0090);
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (dreq) hi++; end
    check("R5 zero count no request", hi, 0);
    wr(2'd1, 16'd8);
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (dreq) hi++; end
    check("R5 late load no request", hi, 0);
    wr(2'd0, 16'h0080);
  endtask

  task automatic t_xfer(input int count, input int code, input int dirbit);
    int bl, rem, eb = 0, er = 0, emax = 0;
    int beats = 0, runs = 0, maxrun = 0, run = 0, low = 0, maxgap = 0;
    int v, late = 0;
    bit eot_seen = 1'b0, upd_ok = 1'b0, started = 1'b0;
    bl = (code == 0) ? 1 : (code == 1) ? 4 : 8;
    rem = count;
    while (rem > 0) begin
      int b;
      b = (rem >= bl * 2) ? bl : 1;
      er++; eb += b; if (b > emax) emax = b;
      rem = (rem > b * 2) ? rem - b * 2 : 0;
    end
    dack = 1'b1; dstrobe = 1'b1;
    wr(2'd0, 16'(8'h80 | (code << 5) | dirbit));
    wr(2'd1, 16'(count));
    wr(2'd0, 16'(8'h90 | (code << 5) | dirbit));
    for (int i = 0; i < 200 && !eot_seen; i++) begin
      @(negedge clk);
      if (dreq) begin
        if (run == 0) begin runs++; if (started && low > maxgap) maxgap = low; end
        started = 1'b1; beats++; run++; low = 0;
        if (run > maxrun) maxrun = run;
      end else begin
        run = 0; low++;
      end
      if (eot_pulse) begin eot_seen = 1'b1; upd_ok = buf_upd; end
    end
    check("R10 eot pulse seen", int'(eot_seen), 1);
    check("R10 buf_upd with eot", int'(upd_ok), 1);
    check("R8 total beats", beats, eb);
    check("R6 R7 burst count", runs, er);
    check("R6 R7 longest burst", maxrun, emax);
    if (er > 1) check("R6 gap one cycle", maxgap, 1);
    check("R10 irq set", int'(irq_eot), 1);
    rd(2'd1, v);
    check("R8 counter empty", v, 0);
    for (int i = 0; i < 5; i++) begin @(negedge clk); if (dreq) late++; end
    check("R10 request stays low", late, 0);
    wr(2'd2, 16'h0000);
    check("R11 write zero keeps flag", int'(irq_eot), 1);
    wr(2'd2, 16'h0004);
    check("R11 write one clears flag", int'(irq_eot), 0);
    wr(2'd0, 16'h0080);
  endtask

  task automatic t_stall();
    int v;
    dack = 1'b0; dstrobe = 1'b1;
    wr(2'd1, 16'd6);
    wr(2'd0, 16'h0090);
    idle(3);
    check("R8 request held under no ack", int'(dreq), 1);
    rd(2'd1, v);
    check("R8 no ack no decrement", v, 6);
    dack = 1'b1; dstrobe = 1'b0;
    idle(3);
    rd(2'd1, v);
    check("R8 no strobe no decrement", v, 6);
    dstrobe = 1'b1;
    @(negedge clk);
    rd(2'd1, v);
    check("R8 one beat decrements 2", v, 4);
    idle(4);
    wr(2'd2, 16'h0004);
    wr(2'd0, 16'h0080);
  endtask

  task automatic t_burst_err();
    int hi = 0;
    dack = 1'b1; dstrobe = 1'b1;
    wr(2'd1, 16'd8);
    wr(2'd0, 16'h00F0);
    check("R9 burst_err set", int'(burst_err), 1);
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (dreq) hi++; end
    check("R9 no request on illegal code", hi, 0);
    wr(2'd0, 16'h0080);
    check("R9 burst_err clear", int'(burst_err), 0);
  endtask

  task automatic t_abort();
    int hi = 0;
    dack = 1'b1; dstrobe = 1'b1;
    wr(2'd1, 16'd40);
    wr(2'd0, 16'h0090);
    idle(3);
    check("R12 request running", int'(dreq), 1);
    @(negedge clk);
    reg_addr = 2'd0; reg_wdata = 16'h0080; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    check("R12 request dropped next cycle", int'(dreq), 0);
    for (int i = 0; i < 5; i++) begin @(negedge clk); if (dreq) hi++; end
    check("R12 request stays low", hi, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done_flag) begin
      done_flag = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg_decode();
    t_cnt_gate();
    t_no_arm();
    t_xfer(8, 1, 0);
    t_xfer(10, 1, 1);
    t_xfer(16, 2, 0);
    t_xfer(20, 2, 1);
    t_xfer(7, 0, 0);
    t_stall();
    t_burst_err();
    t_abort();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule